// File: doc/BRIEF.md
# Bus Yield Arbiter

This block decides when a processor hands its system bus to another bus master and when it takes the bus back. It works in one of two schemes, chosen by a mode input. In the level scheme, a single DMA-style requester raises a hold request. The block answers with a hold acknowledge. In the pulse scheme, each of several channels shares one open-drain line for both request and grant. The requester pulls the line low for one clock to ask. The arbiter pulls the same line low for one clock to grant. The requester pulls it low once more to hand the bus back.

The block never breaks a bus cycle in progress. When it accepts a request, it first tells the local bus sequencer to stop starting new cycles. It hands the bus over only at a cycle boundary, and only while the lock input is released. For as long as another master owns the bus, it tells the sequencer to float its outputs. Each open-drain line appears as two ports: a sensed level coming in and a pull-low enable going out.

Top module: `bus_yield_arb`

## Requirements
- R1: While reset is active and in the first cycle after it, hold_ack, bus_float, yield_req, rg_pull and rg_owner are all 0.
- R2: In level mode (mode_min=1), a hold_req seen while the arbiter is idle sets yield_req on the next cycle. hold_ack and bus_float rise only on the cycle after a clock edge where yield_req, hold_req, seq_idle and lock_n are all 1.
- R3: While lock_n is 0, the bus is not handed over in either mode: bus_float, hold_ack and rg_pull stay 0.
- R4: While seq_idle is 0, the bus is not handed over. The pending request waits with yield_req at 1.
- R5: hold_ack and bus_float drop on the cycle after hold_req is seen low. A hold_req withdrawn while still pending returns the arbiter to idle, and yield_req clears on the next cycle.
- R6: In pulse mode (mode_min=0), a request is a high-to-low change on a channel line rg_in[i], compared with its level at the previous clock edge. Bit i of each vector belongs to channel i. When the arbiter is idle, a request sets yield_req on the next cycle.
- R7: A grant drives rg_pull[i] high (line pulled low) for exactly one cycle. In that same cycle rg_owner becomes one-hot on bit i and bus_float rises. Both stay set while the channel holds the bus.
- R8: A later high-to-low change on the owning channel's line ends the hold. On the next cycle rg_owner, bus_float and yield_req are 0.
- R9: When several channels request in the same cycle, the lowest index wins; channel 0 beats channel 1.
- R10: While one channel's request is pending or holding the bus, requests from any other channel are ignored. This includes a request that falls in the same cycle as the release.
- R11: The mode is sampled only while idle. In level mode, pulses on rg_in start nothing. In pulse mode, hold_req starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_min | input | 1 | 1 selects the level hold scheme, 0 selects the pulse scheme |
| seq_idle | input | 1 | Local sequencer is at a bus cycle boundary |
| lock_n | input | 1 | Bus lock, active low; blocks any hand-over |
| hold_req | input | 1 | Level-mode hold request, active high |
| hold_ack | output | 1 | Level-mode hold acknowledge, active high |
| rg_in | input | NCH | Sensed level of each request/grant line |
| rg_pull | output | NCH | Pull-low enable for each request/grant line |
| rg_owner | output | NCH | One-hot channel that holds or is being granted the bus |
| yield_req | output | 1 | Tells the sequencer to start no new cycle |
| bus_float | output | 1 | Tells the sequencer to float its bus outputs |

## Verification
Two functions can land in the same cycle. The first case is two channels requesting on the same clock edge, which is made to happen by pulling both lines low together; the owner must then be channel 0 alone. The second case is the owner's release pulse arriving on the same edge as a request from the other channel. The bench judges this one by checking that yield_req stays 0 afterwards, so the competing request is dropped. A behavioural model updated every clock is compared against all outputs on every cycle. That model also covers a lock release and a boundary reaching the arbiter together while a request is pending.

// File: rtl/bya_pkg.sv
`timescale 1ns/1ps
package bya_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HPEND = 3'd1,
        ST_HHELD = 3'd2,
        ST_RPEND = 3'd3,
        ST_RGNT  = 3'd4,
        ST_RHELD = 3'd5
    } arb_state_e;

endpackage

// File: rtl/bya_pulse_sense.sv
`timescale 1ns/1ps
// Per-channel falling-edge detector for the shared request/grant lines.
module bya_pulse_sense #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] line,
    output logic [NCH-1:0] fall
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic last_d, last_q;

        always_comb begin
            last_d  = line[g];
            fall[g] = last_q & ~line[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) last_q <= 1'b1;
            else        last_q <= last_d;
        end
    end

endmodule

// File: rtl/bya_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: the lowest index wins.
module bya_pick #(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end

endmodule

// File: rtl/bus_yield_arb.sv
`timescale 1ns/1ps
module bus_yield_arb
    import bya_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_min,
    input  logic           seq_idle,
    input  logic           lock_n,
    input  logic           hold_req,
    output logic           hold_ack,
    input  logic [NCH-1:0] rg_in,
    output logic [NCH-1:0] rg_pull,
    output logic [NCH-1:0] rg_owner,
    output logic           yield_req,
    output logic           bus_float
);

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        arb_state_e     st;
        logic [CHW-1:0] ch;
    } arb_t;

    arb_t arb_d, arb_q;

    logic [NCH-1:0] fall;
    logic           fall_any;
    logic [CHW-1:0] fall_idx;
    logic           may_yield;
    logic [NCH-1:0] ch_oh;

    bya_pulse_sense #(.NCH(NCH)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (rg_in),
        .fall  (fall)
    );

    bya_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req (fall),
        .any (fall_any),
        .idx (fall_idx)
    );

    always_comb begin
        may_yield = seq_idle & lock_n;
        arb_d     = arb_q;
        case (arb_q.st)
            ST_IDLE: begin
                if (mode_min) begin
                    if (hold_req) arb_d.st = ST_HPEND;
                end else if (fall_any) begin
                    arb_d.st = ST_RPEND;
                    arb_d.ch = fall_idx;
                end
            end
            ST_HPEND: begin
                if (!hold_req)     arb_d.st = ST_IDLE;
                else if (may_yield) arb_d.st = ST_HHELD;
            end
            ST_HHELD: begin
                if (!hold_req) arb_d.st = ST_IDLE;
            end
            ST_RPEND: begin
                if (may_yield) arb_d.st = ST_RGNT;
            end
            ST_RGNT:  arb_d.st = ST_RHELD;
            ST_RHELD: begin
                if (fall[arb_q.ch]) arb_d.st = ST_IDLE;
            end
            default:  arb_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q.st <= ST_IDLE;
            arb_q.ch <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    always_comb begin
        ch_oh     = NCH'(1) << arb_q.ch;
        hold_ack  = (arb_q.st == ST_HHELD);
        yield_req = (arb_q.st == ST_HPEND) || (arb_q.st == ST_RPEND);
        bus_float = (arb_q.st == ST_HHELD) || (arb_q.st == ST_RGNT) ||
                    (arb_q.st == ST_RHELD);
        rg_pull   = (arb_q.st == ST_RGNT) ? ch_oh : '0;
        rg_owner  = ((arb_q.st == ST_RGNT) || (arb_q.st == ST_RHELD)) ? ch_oh : '0;
    end

    a_r2_ack_follows_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req) && $past(yield_req));

    a_r3_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float) |-> $past(lock_n));

    a_r4_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float) |-> $past(seq_idle));

    a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack);

    a_r7_grant_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_pull) |=> (rg_pull == '0));

    a_r7_pull_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rg_pull) && $onehot0(rg_owner));

    a_r10_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_owner) |=> (rg_owner == $past(rg_owner)) || (rg_owner == '0));

endmodule

// File: tb/bus_yield_arb_bench.sv
`timescale 1ns/1ps
module bus_yield_arb_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_min = 1'b1;
    logic       seq_idle = 1'b1;
    logic       lock_n = 1'b1;
    logic       hold_req = 1'b0;
    logic [1:0] rq_n = 2'b11;
    logic       hold_ack, yield_req, bus_float;
    logic [1:0] rg_pull, rg_owner, rg_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign rg_line = rq_n & ~rg_pull;

    bus_yield_arb #(.NCH(2)) u_bus_yield_arb (
        .clk(clk), .rst_n(rst_n), .mode_min(mode_min), .seq_idle(seq_idle),
        .lock_n(lock_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .rg_in(rg_line), .rg_pull(rg_pull), .rg_owner(rg_owner),
        .yield_req(yield_req), .bus_float(bus_float)
    );

    // Behavioural reference: 0 idle,1 hold pending,2 hold held,3 rg pending,4 grant,5 rg held
    int       ms = 0;
    int       mch = 0;
    bit [1:0] mprev = 2'b11;

    function automatic bit [1:0] m_pull();
        return (ms == 4) ? 2'(1 << mch) : 2'b00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mch = 0; mprev = 2'b11;
        end else begin
            bit [1:0] ln, fl;
            ln = rq_n & ~m_pull();
            fl = mprev & ~ln;
            mprev = ln;
            case (ms)
                0: if (mode_min) begin
                       if (hold_req) ms = 1;
                   end else if (fl[0]) begin ms = 3; mch = 0; end
                   else if (fl[1]) begin ms = 3; mch = 1; end
                1: if (!hold_req) ms = 0; else if (seq_idle && lock_n) ms = 2;
                2: if (!hold_req) ms = 0;
                3: if (seq_idle && lock_n) ms = 4;
                4: ms = 5;
                5: if (fl[mch]) ms = 0;
                default: ms = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [1:0] eo;
            eo = (ms == 4 || ms == 5) ? 2'(1 << mch) : 2'b00;
            chk(hold_ack == (ms == 2), "R2 model hold_ack", hold_ack, ms == 2);
            chk(yield_req == (ms == 1 || ms == 3), "R6 model yield_req", yield_req, ms == 1 || ms == 3);
            chk(bus_float == (ms == 2 || ms == 4 || ms == 5), "R4 model bus_float", bus_float, ms == 2 || ms == 4 || ms == 5);
            chk(rg_pull == m_pull(), "R7 model rg_pull", rg_pull, m_pull());
            chk(rg_owner == eo, "R8 model rg_owner", rg_owner, eo);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input bit [1:0] which);
        rq_n = ~which;
        tick(1);
        rq_n = 2'b11;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        tick(3);
        chk({hold_ack, bus_float, yield_req, rg_pull, rg_owner} == 7'd0, "R1 in reset", int'({hold_ack, bus_float, yield_req}), 0);
        rst_n = 1'b1;
        tick(1);
        chk({hold_ack, bus_float, yield_req, rg_pull, rg_owner} == 7'd0, "R1 after reset", int'({hold_ack, bus_float, yield_req}), 0);

        // level mode basic
        hold_req = 1; tick(1);
        chk(yield_req == 1 && hold_ack == 0, "R2 pending", yield_req, 1);
        tick(1);
        chk(hold_ack == 1 && bus_float == 1, "R2 acknowledged", hold_ack, 1);
        hold_req = 0; tick(1);
        chk(hold_ack == 0 && bus_float == 0, "R5 drop", hold_ack, 0);

        // lock blocks
        lock_n = 0; hold_req = 1; tick(4);
        chk(hold_ack == 0 && bus_float == 0, "R3 locked level", hold_ack, 0);
        lock_n = 1; tick(1);
        chk(hold_ack == 1, "R3 unlocked level", hold_ack, 1);
        hold_req = 0; tick(1);

        // boundary wait
        seq_idle = 0; hold_req = 1; tick(4);
        chk(hold_ack == 0 && yield_req == 1, "R4 wait boundary", hold_ack, 0);
        seq_idle = 1; tick(1);
        chk(hold_ack == 1, "R4 at boundary", hold_ack, 1);
        hold_req = 0; tick(1);

        // withdrawal while pending
        seq_idle = 0; hold_req = 1; tick(1);
        hold_req = 0; tick(1);
        chk(yield_req == 0 && hold_ack == 0, "R5 withdraw", yield_req, 0);
        seq_idle = 1;

        // level mode ignores lines
        pulse(2'b01); tick(1);
        chk(yield_req == 0 && bus_float == 0, "R11 lines ignored", yield_req, 0);

        // pulse mode ignores hold
        mode_min = 0; tick(1);
        hold_req = 1; tick(3);
        chk(yield_req == 0 && hold_ack == 0, "R11 hold ignored", yield_req, 0);
        hold_req = 0; tick(1);

        // channel 1 request, grant, other channel ignored, release
        pulse(2'b10);
        chk(yield_req == 1, "R6 request seen", yield_req, 1);
        tick(1);
        chk(rg_pull == 2'b10 && rg_owner == 2'b10 && bus_float, "R7 grant", rg_pull, 2);
        tick(1);
        chk(rg_pull == 2'b00 && rg_owner == 2'b10, "R7 pull one clock", rg_pull, 0);
        pulse(2'b01); tick(1);
        chk(rg_owner == 2'b10, "R10 other ignored", rg_owner, 2);
        pulse(2'b10);
        chk(rg_owner == 2'b00 && bus_float == 0, "R8 release", rg_owner, 0);
        tick(2);

        // simultaneous requests, then release colliding with other request
        pulse(2'b11); tick(1);
        chk(rg_owner == 2'b01, "R9 priority", rg_owner, 1);
        tick(2);
        pulse(2'b11); tick(1);
        chk(yield_req == 0 && rg_owner == 2'b00, "R10 release collision", yield_req, 0);

        // lock in pulse mode
        lock_n = 0; pulse(2'b01); tick(3);
        chk(bus_float == 0 && rg_pull == 0, "R3 locked pulse", bus_float, 0);
        lock_n = 1; tick(1);
        chk(rg_pull == 2'b01, "R3 unlocked pulse", rg_pull, 1);
        tick(2);
        pulse(2'b01); tick(2);
        chk(rg_owner == 2'b00, "R8 final release", rg_owner, 0);

        finish_run();
    end

endmodule